// File: doc/BRIEF.md
# Bus-Serviced Watchdog Timer

This block is a watchdog timer that sits on a simple word-wide register port (address, write data, write strobe, registered read data). It holds a 32-bit counter that counts down while it is switched on. Software keeps the system alive by writing one exact key value into a dedicated restart register. That write copies the programmed reload value into the counter. If the counter runs out, the block can fire any of three actions, each gated by the control word: a reset request whose scope (SoC-only or full chip) software chooses, an interrupt that stays set until the next restart, and a pulse on an external watchdog pin.

The counter steps on every peripheral clock, or on a slow tick when software selects it. The slow tick is a one-cycle enable from an internal divider that turns the peripheral clock (CLK_HZ) into TICK_HZ, nominally 1 MHz. Software can turn the block off and change the reload value. It can then write the key and turn the block back on, and no countdown begins until the block is enabled.

Top module: `wdog_periph`

## Requirements
- R1: After reset the control word is 0, the reload value is 0x03EF1480, the counter equals the reload value, and all outputs and read data are 0.
- R2: Reads are registered, one cycle after the address. Byte offset 0x0 returns the counter, 0x4 returns the reload value, 0xC returns the control word in bits [5:0] with zeros above, and 0x8 always returns 0.
- R3: A write of exactly 0x00004755 to offset 0x8 loads the counter from the reload value. A write of any other 32-bit value there, including 0x00014755, changes nothing.
- R4: While control bit 0 (run) is clear, the counter holds and no expiry action occurs. Writing the reload value does not alter the counter until the key is written.
- R5: With run set and bit 4 clear, the counter decrements on every clock. The counter expires on the step taken while it is already zero, then reloads. With reload value N the period is N+1 clocks.
- R6: With bits 0 and 4 set, the counter steps only on the divided tick, which comes once every CLK_HZ/TICK_HZ clocks. The expiry period is (N+1)*CLK_HZ/TICK_HZ clocks.
- R7: On expiry with bit 1 set, a one-cycle reset request appears on rst_soc_o if bit 5 is 0 or on rst_chip_o if bit 5 is 1. With bit 1 clear, neither request fires.
- R8: On expiry with bit 2 set, irq_o rises and stays high until a valid key write clears it. With bit 2 clear, irq_o stays low.
- R9: On expiry with bit 3 set, ext_o pulses high for one cycle.
- R10: A valid key write while running restarts the full countdown, so the next expiry comes N+1 steps after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte offset of the register |
| wr_en | input | 1 | Write strobe |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Sticky expiry interrupt |
| ext_o | output | 1 | One-cycle external watchdog pulse |
| rst_soc_o | output | 1 | One-cycle SoC-scope reset request |
| rst_chip_o | output | 1 | One-cycle full-chip reset request |

## Verification
Register writes take effect at the clock edge that samples them. Read data is valid one cycle after the address is presented, so reads are sampled just after that edge. In per-clock mode, if the enabling or key write lands at edge C, the first expiry pulse and the interrupt rise are visible right after edge C+N+1, and later pulses follow every N+1 edges. The driver pushes these exact cycle numbers into a queue, and a monitor sampling on the falling edge pops and compares them against each pulse it sees. In tick mode the divider phase is not visible at the ports, so the bench measures the spacing between successive pulses and expects (N+1)*divisor clocks.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CTRL_W     = 6;
  localparam int OFF_COUNT  = 'h0;
  localparam int OFF_RELOAD = 'h4;
  localparam int OFF_KICK   = 'h8;
  localparam int OFF_CTRL   = 'hC;

  // bit order matters: software encodes these positions
  typedef struct packed {
    logic scope_chip; // bit 5
    logic tick_sel;   // bit 4
    logic ext_en;     // bit 3
    logic irq_en;     // bit 2
    logic rst_en;     // bit 1
    logic run;        // bit 0
  } ctrl_t;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pcnt_q;

      always_ff @(posedge clk) begin
        if (rst)                  pcnt_q <= '0;
        else if (pcnt_q == LAST)  pcnt_q <= '0;
        else                      pcnt_q <= pcnt_q + 1'b1;
      end

      assign tick_o = (pcnt_q == LAST);

      // R6: the divided tick is never high on two clocks in a row
      assert_tick_gap_R6: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int              ADDR_W      = 4,
  parameter int              DATA_W      = 32,
  parameter logic [31:0]     RELOAD_INIT = 32'h03EF1480,
  parameter logic [15:0]     KEY         = 16'h4755
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] cnt_i,
  output logic [DATA_W-1:0] rdata_o,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] reload_o,
  output logic              kick_o
);
  localparam logic [ADDR_W-1:0] A_COUNT  = ADDR_W'(OFF_COUNT);
  localparam logic [ADDR_W-1:0] A_RELOAD = ADDR_W'(OFF_RELOAD);
  localparam logic [ADDR_W-1:0] A_KICK   = ADDR_W'(OFF_KICK);
  localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFF_CTRL);
  localparam logic [DATA_W-1:0] KEY_WORD = DATA_W'(KEY);

  ctrl_t             ctrl_q;
  logic [DATA_W-1:0] reload_q;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    case (addr)
      A_COUNT:  rd_mux = cnt_i;
      A_RELOAD: rd_mux = reload_q;
      A_CTRL:   rd_mux = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      reload_q <= DATA_W'(RELOAD_INIT);
      rdata_q  <= '0;
    end else begin
      rdata_q <= rd_mux;
      if (wr_en && addr == A_CTRL)   ctrl_q   <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (wr_en && addr == A_RELOAD) reload_q <= wdata;
    end
  end

  assign kick_o   = wr_en && (addr == A_KICK) && (wdata == KEY_WORD);
  assign ctrl_o   = ctrl_q;
  assign reload_o = reload_q;
  assign rdata_o  = rdata_q;

  // R4: the reload value only changes through a write to its own offset
  assert_reload_write_only_R4: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && addr == A_RELOAD) |=> $stable(reload_q));
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter logic [31:0] RELOAD_INIT = 32'h03EF1480
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl_i,
  input  logic              tick_i,
  input  logic              kick_i,
  input  logic [DATA_W-1:0] reload_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              irq_o,
  output logic              ext_o,
  output logic              rst_soc_o,
  output logic              rst_chip_o
);
  logic [DATA_W-1:0] cnt_q;
  logic irq_q, ext_q, soc_q, chip_q;
  logic step, expire;

  assign step   = ctrl_i.tick_sel ? tick_i : 1'b1;
  assign expire = ctrl_i.run && step && (cnt_q == '0) && !kick_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= DATA_W'(RELOAD_INIT);
      irq_q  <= 1'b0;
      ext_q  <= 1'b0;
      soc_q  <= 1'b0;
      chip_q <= 1'b0;
    end else begin
      soc_q  <= expire && ctrl_i.rst_en && !ctrl_i.scope_chip;
      chip_q <= expire && ctrl_i.rst_en &&  ctrl_i.scope_chip;
      ext_q  <= expire && ctrl_i.ext_en;

      if (kick_i || expire)          cnt_q <= reload_i;
      else if (ctrl_i.run && step)   cnt_q <= cnt_q - 1'b1;

      if (kick_i)                        irq_q <= 1'b0;
      else if (expire && ctrl_i.irq_en)  irq_q <= 1'b1;
    end
  end

  assign cnt_o      = cnt_q;
  assign irq_o      = irq_q;
  assign ext_o      = ext_q;
  assign rst_soc_o  = soc_q;
  assign rst_chip_o = chip_q;

  // R3: a valid key write loads the reload value
  assert_kick_load_R3: assert property (@(posedge clk) disable iff (rst)
    kick_i |=> (cnt_q == $past(reload_i)));

  // R4: stopped and not kicked means the counter holds
  assert_hold_when_off_R4: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_i.run && !kick_i) |=> $stable(cnt_q));

  // R5: a step on a nonzero count takes exactly one off
  assert_step_dec_R5: assert property (@(posedge clk) disable iff (rst)
    (ctrl_i.run && step && !kick_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  // R7: a reset request only follows an expiry with the request enabled
  assert_rst_gate_R7: assert property (@(posedge clk) disable iff (rst)
    (soc_q || chip_q) |-> $past(ctrl_i.rst_en && ctrl_i.run));

  // R8: the interrupt only rises from an enabled expiry
  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(ctrl_i.irq_en && expire));
endmodule

// File: rtl/wdog_periph.sv
module wdog_periph
  import wdog_pkg::*;
#(
  parameter int          CLK_HZ      = 50_000_000,
  parameter int          TICK_HZ     = 1_000_000,
  parameter int          ADDR_W      = 4,
  parameter int          DATA_W      = 32,
  parameter logic [31:0] RELOAD_INIT = 32'h03EF1480,
  parameter logic [15:0] KEY         = 16'h4755
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              irq_o,
  output logic              ext_o,
  output logic              rst_soc_o,
  output logic              rst_chip_o
);
  localparam int DIV = (CLK_HZ / TICK_HZ) < 1 ? 1 : (CLK_HZ / TICK_HZ);

  ctrl_t             ctrl;
  logic [DATA_W-1:0] reload_val;
  logic [DATA_W-1:0] cnt;
  logic              kick;
  logic              tick;

  wdog_prescaler #(.DIV(DIV)) u_presc (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  wdog_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RELOAD_INIT(RELOAD_INIT), .KEY(KEY)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .wr_en    (wr_en),
    .wdata    (wdata),
    .cnt_i    (cnt),
    .rdata_o  (rdata),
    .ctrl_o   (ctrl),
    .reload_o (reload_val),
    .kick_o   (kick)
  );

  wdog_core #(.DATA_W(DATA_W), .RELOAD_INIT(RELOAD_INIT)) u_core (
    .clk        (clk),
    .rst        (rst),
    .ctrl_i     (ctrl),
    .tick_i     (tick),
    .kick_i     (kick),
    .reload_i   (reload_val),
    .cnt_o      (cnt),
    .irq_o      (irq_o),
    .ext_o      (ext_o),
    .rst_soc_o  (rst_soc_o),
    .rst_chip_o (rst_chip_o)
  );

  // R7: the two reset scopes never request together
  assert_one_scope_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rst_soc_o, rst_chip_o}));
endmodule

// File: tb/wdog_periph_tb_top.sv
module wdog_periph_tb_top;
  localparam int DIV = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq_o, ext_o, rst_soc_o, rst_chip_o;

  wdog_periph #(.CLK_HZ(10_000_000), .TICK_HZ(1_000_000)) dut_i (
    .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rdata(rdata), .irq_o(irq_o), .ext_o(ext_o),
    .rst_soc_o(rst_soc_o), .rst_chip_o(rst_chip_o)
  );

  always #2 clk = ~clk; // 250 MHz

  typedef struct { int cyc; logic [2:0] v; } item_t; // v = {chip, soc, ext}
  item_t exp_q[$];

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int last_edge = 0;
  bit sb_on = 1'b1;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  // monitor: every pulse must match the head of the expectation queue
  always @(negedge clk) begin
    if (!rst && sb_on && (rst_chip_o || rst_soc_o || ext_o)) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7", "unexpected pulse", {29'd0, rst_chip_o, rst_soc_o, ext_o}, 32'd0);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        chk(it.cyc == cyc, "R5", "pulse cycle", cyc, it.cyc);
        chk(it.v == {rst_chip_o, rst_soc_o, ext_o}, "R7", "pulse kind",
            {29'd0, rst_chip_o, rst_soc_o, ext_o}, {29'd0, it.v});
      end
    end
  end

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
    last_edge = cyc;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    @(posedge clk); #1;
    d = rdata;
  endtask

  task automatic wait_cyc(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic push(int c, logic [2:0] v);
    item_t it;
    it.cyc = c; it.v = v;
    exp_q.push_back(it);
  endtask

  task automatic wait_ext(output int at);
    int n = 0;
    @(negedge clk);
    while (!ext_o && n < 2000) begin @(negedge clk); n++; end
    at = cyc;
  endtask

  initial begin
    logic [31:0] v;
    int c0, p1, p2, p3;
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    chk({irq_o, ext_o, rst_soc_o, rst_chip_o} == 4'b0, "R1", "outputs after reset",
        {irq_o, ext_o, rst_soc_o, rst_chip_o}, 0);
    rd(4'h0, v); chk(v == 32'h03EF1480, "R1", "counter after reset", v, 32'h03EF1480);
    rd(4'h4, v); chk(v == 32'h03EF1480, "R1", "reload after reset", v, 32'h03EF1480);
    rd(4'hC, v); chk(v == 0, "R1", "control after reset", v, 0);

    // R2 read map, R3 wrong keys, R4 reload write while stopped
    wr(4'h4, 32'h1234_5678);
    rd(4'h4, v); chk(v == 32'h1234_5678, "R2", "reload readback", v, 32'h1234_5678);
    wr(4'hC, 32'hFFFF_FF30);
    rd(4'hC, v); chk(v == 32'h30, "R2", "control readback", v, 32'h30);
    rd(4'h8, v); chk(v == 0, "R2", "restart reads zero", v, 0);
    rd(4'h0, v); chk(v == 32'h03EF1480, "R4", "reload write leaves counter", v, 32'h03EF1480);
    wr(4'h8, 32'h0000_4756);
    rd(4'h0, v); chk(v == 32'h03EF1480, "R3", "wrong key ignored", v, 32'h03EF1480);
    wr(4'h8, 32'h0001_4755);
    rd(4'h0, v); chk(v == 32'h03EF1480, "R3", "key with upper bits ignored", v, 32'h03EF1480);
    wr(4'h8, 32'h0000_4755);
    rd(4'h0, v); chk(v == 32'h1234_5678, "R3", "key loads counter", v, 32'h1234_5678);
    repeat (20) @(negedge clk);
    rd(4'h0, v); chk(v == 32'h1234_5678, "R4", "stopped counter holds", v, 32'h1234_5678);

    // R5 R7 R8 R9: per-clock, soc scope, irq and ext on, N=20
    wr(4'hC, 0);
    wr(4'h4, 20);
    wr(4'h8, 32'h4755);
    wr(4'hC, 32'h0F);
    c0 = last_edge;
    push(c0 + 21, 3'b011);
    push(c0 + 42, 3'b011);
    wait_cyc(c0 + 20); chk(irq_o == 1'b0, "R8", "irq low before expiry", irq_o, 0);
    wait_cyc(c0 + 21); chk(irq_o == 1'b1, "R8", "irq high at expiry", irq_o, 1);
    wait_cyc(c0 + 50);
    wr(4'hC, 0);
    chk(exp_q.size() == 0, "R5", "both periodic expiries seen", exp_q.size(), 0);
    repeat (5) @(negedge clk);
    chk(irq_o == 1'b1, "R8", "irq sticky", irq_o, 1);
    wr(4'h8, 32'h4755);
    chk(irq_o == 1'b0, "R8", "key clears irq", irq_o, 0);

    // R10 R7: chip scope, key mid-countdown, N=30
    wr(4'h4, 30);
    wr(4'h8, 32'h4755);
    wr(4'hC, 32'h23);
    c0 = last_edge;
    wait_cyc(c0 + 20);
    wr(4'h8, 32'h4755);
    push(last_edge + 31, 3'b100);
    wait_cyc(c0 + 60);
    wr(4'hC, 0);
    chk(exp_q.size() == 0, "R10", "postponed chip expiry seen", exp_q.size(), 0);
    chk(irq_o == 1'b0, "R8", "irq stays low when disabled", irq_o, 0);

    // R7: run only, no actions, N=10 -> no pulses allowed
    wr(4'h4, 10);
    wr(4'h8, 32'h4755);
    wr(4'hC, 32'h01);
    repeat (40) @(negedge clk);
    wr(4'hC, 0);
    chk(irq_o == 1'b0 && exp_q.size() == 0, "R7", "no action without enables", irq_o, 0);

    // R6 R9: tick mode, ext only, N=5 -> period 60
    sb_on = 1'b0;
    wr(4'h4, 5);
    wr(4'h8, 32'h4755);
    wr(4'hC, 32'h19);
    wait_ext(p1);
    @(negedge clk); chk(ext_o == 1'b0, "R9", "ext pulse one cycle", ext_o, 0);
    wait_ext(p2);
    wait_ext(p3);
    wr(4'hC, 0);
    chk(p2 - p1 == 6 * DIV, "R6", "tick period 1", p2 - p1, 6 * DIV);
    chk(p3 - p2 == 6 * DIV, "R6", "tick period 2", p3 - p2, 6 * DIV);
    repeat (4) @(negedge clk);
    sb_on = 1'b1;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule